// File: doc/BRIEF.md
# Memory Request Statistics Gatherer

This block watches the grant stream of a memory arbiter and counts selected events for performance analysis. Every cycle the arbiter may present one grant, made up of the winning requester's 6-bit ID, its read/write direction, three accompanying priority signals (high-priority, timeout, bandwidth) and flags for page miss, auto-precharge and bank A/B arbitration. Two event counters each have a control word. The control word chooses an event kind, can restrict counting to a single requester ID, and can require one selected priority signal to be low or high. A free-running clock counter measures the length of the gathering window and stops at a programmable limit.

Software programs the control words and the clock limit through a simple register port. It issues reset, clear, freeze or run commands, runs a window, freezes it and reads the counts back. Converting counts into utilisation figures is left to software. The grant input uses valid/ready, but the gatherer is a passive observer. It drives ready high permanently and never back-pressures, so the arbiter may present a grant with valid on any cycle. A grant is observed only in a cycle where valid is high.

Top module: `mem_stat_gatherer`

## Requirements
- R1: Register map by word address: 0 global command, 1 clock limit, 2 clock count (read-only), 4 and 5 control words of counters 0 and 1, 8 and 9 counts of counters 0 and 1. Other addresses read 0. Address 0 reads 0x300 while running and 0x200 otherwise. A control word reads back masked to its fields: requester ID bits 13:8, event select bits 23:16, priority select bits 25:24, ID-filter enable bit 26, priority filter mode bits 29:28. The clock limit resets to all ones.
- R2: A write to address 0 takes its command from bits 9:8. 0 (reset) zeroes both counts and the clock count, forgets the previous grant and freezes. 1 (clear) zeroes the counts and the clock count but keeps the run state and the previous grant. 2 freezes and 3 runs. After hardware reset the block is frozen with all counts 0.
- R3: While frozen, no count and no clock count changes, whatever grants arrive.
- R4: While running, the clock count increments once per cycle as long as it is below the clock limit, and then holds.
- R5: Event select codes: 0 any grant, 1 read grant, 2 write grant, 5 bank A arbitration flag, 6 bank B arbitration flag, 7 page-miss flag, 8 auto-precharge flag. Codes 9 and above never count.
- R6: Code 4 (successive win) counts a grant whose requester ID equals that of the previous valid grant, so N back-to-back wins by one requester count N-1.
- R7: Code 3 (direction change) counts a grant whose write flag differs from that of the previous valid grant. Every valid grant becomes the previous grant, whether the block is running or frozen. After a reset command or hardware reset there is no previous grant, so codes 3 and 4 do not count the first grant.
- R8: With the ID-filter enable set, a counter only counts grants whose ID equals the programmed ID. With it clear, grants from all requesters count.
- R9: Priority select 0/1/2 picks the high-priority, timeout or bandwidth signal; select 3 reads as low. Filter mode 1 counts only when the picked signal is low and mode 2 only when it is high. Modes 0 and 3 do not filter.
- R10: gnt_ready is always 1, and a grant with gnt_valid low never counts.
- R11: A register write changes the block's state at the clock edge that ends the write cycle. A grant in the same cycle is judged with the old control word and the old run state. When a clear or reset command falls in the same cycle as a counting grant, the command wins and the count ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| gnt_valid | input | 1 | A grant is present this cycle |
| gnt_ready | output | 1 | Always high: the observer never back-pressures |
| gnt_id | input | 6 | Winning requester ID |
| gnt_write | input | 1 | 1 for a write grant, 0 for a read |
| gnt_hp | input | 1 | High-priority signal with the grant |
| gnt_tm | input | 1 | Timeout signal with the grant |
| gnt_bw | input | 1 | Bandwidth signal with the grant |
| gnt_page_miss | input | 1 | Grant caused a page miss |
| gnt_auto_pre | input | 1 | Grant used auto-precharge |
| gnt_bank_a | input | 1 | Bank A arbitration flag |
| gnt_bank_b | input | 1 | Bank B arbitration flag |

## Verification
A register write and a counting grant can land in the same cycle. Of these, the clear command colliding with a matching grant and a control-word rewrite colliding with a grant are the cases that matter. The bench sets up both deliberately. In one cycle it presents a grant that the current setup would count together with a clear command. In another it presents a grant together with a control write that would change the verdict. The bench judges the result by reading the counts back. The clear must leave 0 and the grant must be scored under the old control word. The random rounds also mix clear commands into live grant traffic, and the bench model applies the same ordering to them.

// File: rtl/msg_pkg.sv
package msg_pkg;

  localparam int ID_W  = 6;
  localparam int EVT_W = 8;

  typedef enum logic [1:0] {
    CMD_RESET  = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_FREEZE = 2'd2,
    CMD_RUN    = 2'd3
  } gather_cmd_e;

  localparam logic [EVT_W-1:0] EV_ANY      = 8'd0;
  localparam logic [EVT_W-1:0] EV_READ     = 8'd1;
  localparam logic [EVT_W-1:0] EV_WRITE    = 8'd2;
  localparam logic [EVT_W-1:0] EV_DIR_CHG  = 8'd3;
  localparam logic [EVT_W-1:0] EV_REPEAT   = 8'd4;
  localparam logic [EVT_W-1:0] EV_BANK_A   = 8'd5;
  localparam logic [EVT_W-1:0] EV_BANK_B   = 8'd6;
  localparam logic [EVT_W-1:0] EV_PG_MISS  = 8'd7;
  localparam logic [EVT_W-1:0] EV_AUTO_PRE = 8'd8;

  localparam logic [1:0] PSEL_HP = 2'd0;
  localparam logic [1:0] PSEL_TM = 2'd1;
  localparam logic [1:0] PSEL_BW = 2'd2;

  localparam logic [1:0] PF_LOW  = 2'd1;
  localparam logic [1:0] PF_HIGH = 2'd2;

  localparam logic [31:0] CTL_MASK = 32'h37FF_3F00;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            write;
    logic            hp;
    logic            tm;
    logic            bw;
    logic            page_miss;
    logic            auto_pre;
    logic            bank_a;
    logic            bank_b;
  } grant_t;

  typedef struct packed {
    logic [1:0]       pmode;
    logic             id_en;
    logic [1:0]       psel;
    logic [EVT_W-1:0] evt;
    logic [ID_W-1:0]  id;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [31:0] w);
    ctl_t c;
    c.id    = w[13:8];
    c.evt   = w[23:16];
    c.psel  = w[25:24];
    c.id_en = w[26];
    c.pmode = w[29:28];
    return c;
  endfunction

endpackage

// File: rtl/msg_history.sv
module msg_history
  import msg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            valid,
  input  grant_t          grant,
  output logic            prev_valid,
  output logic [ID_W-1:0] prev_id,
  output logic            prev_write
);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      prev_valid <= 1'b0;
      prev_id    <= '0;
      prev_write <= 1'b0;
    end else if (valid) begin
      prev_valid <= 1'b1;
      prev_id    <= grant.id;
      prev_write <= grant.write;
    end
  end

endmodule

// File: rtl/msg_evt_unit.sv
module msg_evt_unit
  import msg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  ctl_t             ctl,
  input  logic             valid,
  input  grant_t           grant,
  input  logic             prev_valid,
  input  logic [ID_W-1:0]  prev_id,
  input  logic             prev_write,
  output logic [CNT_W-1:0] count
);

  logic pri_sig;
  logic pri_ok;
  logic id_ok;
  logic evt_ok;
  logic hit;

  always_comb begin
    unique case (ctl.psel)
      PSEL_HP: pri_sig = grant.hp;
      PSEL_TM: pri_sig = grant.tm;
      PSEL_BW: pri_sig = grant.bw;
      default: pri_sig = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctl.pmode)
      PF_LOW:  pri_ok = !pri_sig;
      PF_HIGH: pri_ok = pri_sig;
      default: pri_ok = 1'b1;
    endcase
  end

  assign id_ok = !ctl.id_en || (grant.id == ctl.id);

  always_comb begin
    unique case (ctl.evt)
      EV_ANY:      evt_ok = 1'b1;
      EV_READ:     evt_ok = !grant.write;
      EV_WRITE:    evt_ok = grant.write;
      EV_DIR_CHG:  evt_ok = prev_valid && (prev_write != grant.write);
      EV_REPEAT:   evt_ok = prev_valid && (prev_id == grant.id);
      EV_BANK_A:   evt_ok = grant.bank_a;
      EV_BANK_B:   evt_ok = grant.bank_b;
      EV_PG_MISS:  evt_ok = grant.page_miss;
      EV_AUTO_PRE: evt_ok = grant.auto_pre;
      default:     evt_ok = 1'b0;
    endcase
  end

  assign hit = valid && id_ok && pri_ok && evt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (run && hit) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/msg_clk_counter.sv
module msg_clk_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else if (run && (count < limit)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/mem_stat_gatherer.sv
module mem_stat_gatherer
  import msg_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              gnt_valid,
  output logic              gnt_ready,
  input  logic [ID_W-1:0]   gnt_id,
  input  logic              gnt_write,
  input  logic              gnt_hp,
  input  logic              gnt_tm,
  input  logic              gnt_bw,
  input  logic              gnt_page_miss,
  input  logic              gnt_auto_pre,
  input  logic              gnt_bank_a,
  input  logic              gnt_bank_b
);

  localparam int CTL_BASE = 2 ** (ADDR_W - 2);
  localparam int CNT_BASE = 2 ** (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(2);

  grant_t           grant;
  logic             run_q;
  logic             cmd_wr;
  gather_cmd_e      wcmd;
  logic             limit_wr;
  logic             clear_all;
  logic             flush_hist;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] clk_cnt;
  logic [31:0]      ctl_q   [NUM_CNT];
  logic [CNT_W-1:0] cnt     [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic             prev_valid;
  logic [ID_W-1:0]  prev_id;
  logic             prev_write;

  assign gnt_ready = 1'b1;

  assign grant = '{id: gnt_id, write: gnt_write, hp: gnt_hp, tm: gnt_tm,
                   bw: gnt_bw, page_miss: gnt_page_miss,
                   auto_pre: gnt_auto_pre, bank_a: gnt_bank_a,
                   bank_b: gnt_bank_b};

  assign cmd_wr     = reg_we && (reg_addr == A_CMD);
  assign wcmd       = gather_cmd_e'(reg_wdata[9:8]);
  assign limit_wr   = reg_we && (reg_addr == A_LIMIT);
  assign clear_all  = cmd_wr && ((wcmd == CMD_RESET) || (wcmd == CMD_CLEAR));
  assign flush_hist = cmd_wr && (wcmd == CMD_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (cmd_wr) begin
      unique case (wcmd)
        CMD_RESET:  run_q <= 1'b0;
        CMD_CLEAR:  run_q <= run_q;
        CMD_FREEZE: run_q <= 1'b0;
        CMD_RUN:    run_q <= 1'b1;
        default:    run_q <= run_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '1;
    end else if (limit_wr) begin
      limit_q <= reg_wdata[CNT_W-1:0];
    end
  end

  msg_history u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_hist),
    .valid      (gnt_valid),
    .grant      (grant),
    .prev_valid (prev_valid),
    .prev_id    (prev_id),
    .prev_write (prev_write)
  );

  msg_clk_counter #(.CNT_W(CNT_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clear (clear_all),
    .limit (limit_q),
    .count (clk_cnt)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_BASE + i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[i] <= '0;
      end else if (reg_we && (reg_addr == A_CTL)) begin
        ctl_q[i] <= reg_wdata;
      end
    end

    msg_evt_unit #(.CNT_W(CNT_W)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_q),
      .clear      (clear_all),
      .ctl        (unpack_ctl(ctl_q[i])),
      .valid      (gnt_valid),
      .grant      (grant),
      .prev_valid (prev_valid),
      .prev_id    (prev_id),
      .prev_write (prev_write),
      .count      (cnt[i])
    );

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CMD) begin
      reg_rdata = {22'd0, 1'b1, run_q, 8'd0};
    end else if (reg_addr == A_LIMIT) begin
      reg_rdata = 32'(limit_q);
    end else if (reg_addr == A_CLK) begin
      reg_rdata = 32'(clk_cnt);
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(CTL_BASE + i)) reg_rdata = ctl_q[i] & CTL_MASK;
      if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata = 32'(cnt[i]);
    end
  end

endmodule

// File: rtl/msg_checker.sv
module msg_checker #(
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run,
  input logic                     cmd_wr,
  input logic [1:0]               cmd,
  input logic                     limit_wr,
  input logic                     gnt_ready,
  input logic [CNT_W-1:0]         clk_cnt,
  input logic [CNT_W-1:0]         limit,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_ready == 1'b1);

  p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd_wr) |=> ($stable(clk_cnt) && $stable(cnt_flat)));

  p_clock_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmd_wr && !limit_wr && (clk_cnt >= limit)) |=> $stable(clk_cnt));

  p_reset_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 2'd0) |=> (clk_cnt == '0 && cnt_flat == '0 && !run));

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == 2'd1) |=> (cnt_flat == '0 && run == $past(run)));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> ((cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W])) ||
                   (cnt_flat[i*CNT_W +: CNT_W] == $past(cnt_flat[i*CNT_W +: CNT_W]) + 1'b1)));
  end

endmodule

bind mem_stat_gatherer msg_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .cmd_wr    (cmd_wr),
  .cmd       (reg_wdata[9:8]),
  .limit_wr  (limit_wr),
  .gnt_ready (gnt_ready),
  .clk_cnt   (clk_cnt),
  .limit     (limit_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/mem_stat_gatherer_bench.sv
`timescale 1ns/1ps
module mem_stat_gatherer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        gnt_valid = 1'b0;
  logic        gnt_ready;
  logic [5:0]  gnt_id = '0;
  logic [7:0]  fl = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  bit          m_run;
  logic [31:0] m_clk, m_lim;
  logic [31:0] m_ctl [2];
  logic [31:0] m_cnt [2];
  bit          m_pv, m_pw;
  logic [5:0]  m_pid;

  always #2.5 clk = ~clk;

  mem_stat_gatherer u_mem_stat_gatherer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_id(gnt_id),
    .gnt_write(fl[7]), .gnt_hp(fl[6]), .gnt_tm(fl[5]), .gnt_bw(fl[4]),
    .gnt_page_miss(fl[3]), .gnt_auto_pre(fl[2]), .gnt_bank_a(fl[1]),
    .gnt_bank_b(fl[0]));

  // fl bits: 7 write, 6 hp, 5 tm, 4 bw, 3 page miss, 2 auto-pre, 1 bank A, 0 bank B
  function automatic bit m_hit(logic [31:0] c, logic [5:0] id, logic [7:0] f);
    bit sig, pok, iok, eok;
    case (c[25:24])
      2'd0: sig = f[6];
      2'd1: sig = f[5];
      2'd2: sig = f[4];
      default: sig = 1'b0;
    endcase
    pok = (c[29:28] == 2'd1) ? !sig : (c[29:28] == 2'd2) ? sig : 1'b1;
    iok = !c[26] || (c[13:8] == id);
    case (c[23:16])
      8'd0: eok = 1;
      8'd1: eok = !f[7];
      8'd2: eok = f[7];
      8'd3: eok = m_pv && (m_pw != f[7]);
      8'd4: eok = m_pv && (m_pid == id);
      8'd5: eok = f[1];
      8'd6: eok = f[0];
      8'd7: eok = f[3];
      8'd8: eok = f[2];
      default: eok = 0;
    endcase
    return pok && iok && eok;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_run ? 32'h300 : 32'h200;
      4'd1: return m_lim;
      4'd2: return m_clk;
      4'd4: return m_ctl[0] & 32'h37FF_3F00;
      4'd5: return m_ctl[1] & 32'h37FF_3F00;
      4'd8: return m_cnt[0];
      4'd9: return m_cnt[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_clk = 0; m_lim = '1; m_pv = 0; m_pw = 0; m_pid = 0;
    for (int i = 0; i < 2; i++) begin m_ctl[i] = 0; m_cnt[i] = 0; end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] wd,
                      input bit v, input logic [5:0] id, input logic [7:0] f);
    bit h [2];
    reg_we = we; reg_addr = a; reg_wdata = wd;
    gnt_valid = v; gnt_id = id; fl = f;
    for (int i = 0; i < 2; i++) h[i] = v && m_hit(m_ctl[i], id, f);
    @(posedge clk);
    if (m_run) begin
      for (int i = 0; i < 2; i++) if (h[i]) m_cnt[i] = m_cnt[i] + 1;
      if (m_clk < m_lim) m_clk = m_clk + 1;
    end
    if (v) begin m_pv = 1; m_pw = f[7]; m_pid = id; end
    if (we) begin
      case (a)
        4'd0: case (wd[9:8])
          2'd0: begin m_cnt[0] = 0; m_cnt[1] = 0; m_clk = 0; m_pv = 0; m_run = 0; end
          2'd1: begin m_cnt[0] = 0; m_cnt[1] = 0; m_clk = 0; end
          2'd2: m_run = 0;
          default: m_run = 1;
        endcase
        4'd1: m_lim = wd;
        4'd4: m_ctl[0] = wd;
        4'd5: m_ctl[1] = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    reg_we = 0; gnt_valid = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic gr(input logic [5:0] id, input logic [7:0] f);
    step(0, 0, 0, 1, id, f);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string req, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    chk(req, v, m_read(a));
  endtask

  function automatic logic [31:0] ctlw(int evt, int id, bit en, int psel, int pm);
    return (32'(pm) << 28) | (32'(en) << 26) | (32'(psel) << 24) |
           (32'(evt) << 16) | (32'(id) << 8);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R10: reset state
    rd(4'd8, "R2 count0 after reset", v);       chk("R2 count0 zero", v, 0);
    rd(4'd2, "R2 clock after reset", v);        chk("R2 clock zero", v, 0);
    rd(4'd1, "R1 limit reset value", v);        chk("R1 limit all ones", v, 32'hFFFF_FFFF);
    rd(4'd0, "R1 global frozen", v);            chk("R1 global 0x200", v, 32'h200);
    rd(4'd3, "R1 unused address", v);
    chk("R10 ready high", {31'd0, gnt_ready}, 1);
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, "R1 control mask", v);             chk("R1 ctl mask", v, 32'h37FF_3F00);

    // R6 successive wins, with R8 filter on counter 1
    wr(4'd4, ctlw(4, 0, 0, 0, 0));
    wr(4'd5, ctlw(4, 5, 1, 0, 0));
    wr(4'd0, 32'h000);
    wr(4'd0, 32'h300);
    for (int i = 0; i < 4; i++) gr(6'd5, 8'h00);
    gr(6'd3, 8'h00); gr(6'd3, 8'h00);
    wr(4'd0, 32'h200);
    rd(4'd8, "R6 successive any", v);           chk("R6 N-1 per run", v, 4);
    rd(4'd9, "R8 successive filtered", v);      chk("R8 id filter", v, 3);

    // R7 direction change; R5 read count; valid gap keeps history
    wr(4'd4, ctlw(3, 0, 0, 0, 0));
    wr(4'd5, ctlw(1, 0, 0, 0, 0));
    wr(4'd0, 32'h000);
    wr(4'd0, 32'h300);
    gr(1, 8'h00); gr(1, 8'h00); idle(2); gr(2, 8'h80); gr(2, 8'h80); gr(4, 8'h00);
    wr(4'd0, 32'h200);
    rd(4'd8, "R7 direction changes", v);        chk("R7 two changes", v, 2);
    rd(4'd9, "R5 read grants", v);              chk("R5 three reads", v, 3);

    // R9 priority filter on timeout signal
    wr(4'd4, ctlw(0, 0, 0, 1, 2));
    wr(4'd5, ctlw(0, 0, 0, 1, 1));
    wr(4'd0, 32'h000);
    wr(4'd0, 32'h300);
    gr(0, 8'h20); gr(0, 8'h00); gr(0, 8'h20); gr(0, 8'h60); gr(0, 8'h50);
    wr(4'd0, 32'h200);
    rd(4'd8, "R9 signal high", v);              chk("R9 high mode", v, 3);
    rd(4'd9, "R9 signal low", v);               chk("R9 low mode", v, 2);

    // R3 frozen: nothing moves
    wr(4'd4, ctlw(0, 0, 0, 0, 0));
    for (int i = 0; i < 5; i++) gr(6'(i), 8'hFF);
    rd(4'd8, "R3 frozen count", v);             chk("R3 count held", v, 3);
    rd(4'd2, "R3 frozen clock", v);

    // R10 invalid grants ignored
    wr(4'd0, 32'h000);
    wr(4'd0, 32'h300);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 6'(i), 8'hFF);
    rd(4'd8, "R10 no valid no count", v);       chk("R10 zero", v, 0);

    // R11 clear together with counting grant; control write with grant
    gr(1, 8'h00); gr(1, 8'h00);
    step(1, 4'd0, 32'h100, 1, 1, 8'h00);
    rd(4'd8, "R11 clear wins", v);              chk("R11 zero after clear", v, 0);
    rd(4'd0, "R2 clear keeps run", v);          chk("R2 still running", v, 32'h300);
    step(1, 4'd4, ctlw(9, 0, 0, 0, 0), 1, 1, 8'h00);
    gr(1, 8'h00);
    rd(4'd8, "R11 old control used", v);        chk("R11 one count", v, 1);

    // R4 clock limit
    wr(4'd1, 32'd10);
    wr(4'd0, 32'h000);
    wr(4'd0, 32'h300);
    idle(20);
    rd(4'd2, "R4 clock saturates", v);          chk("R4 at limit", v, 10);
    wr(4'd1, 32'hFFFF_FFFF);

    // R5 R8 R9 R7 R6: random rounds
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 2; k++)
        wr(4'(4 + k), ctlw($urandom % 11, $urandom % 4, 1'($urandom % 2),
                           $urandom % 4, $urandom % 4));
      wr(4'd0, (r % 2 == 0) ? 32'h000 : 32'h100);
      wr(4'd0, 32'h300);
      for (int c = 0; c < 300; c++) begin
        if ($urandom % 97 == 0) step(1, 4'd0, 32'h100, 1, 6'($urandom % 4), 8'($urandom));
        else step(0, 0, 0, ($urandom % 4) != 0, 6'($urandom % 4), 8'($urandom));
      end
      wr(4'd0, 32'h200);
      rd(4'd8, "R5 random counter0", v);
      rd(4'd9, "R5 random counter1", v);
      rd(4'd2, "R4 random clock", v);
    end

    finish_run();
  end

endmodule